// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block holds the digital sequencing for an integrating converter of the dual-slope kind. A host requests a conversion. The block then clears one binary counter and opens the shunt switch that shorts the integrator capacitor. The counter then runs up at the clock rate. While its top bit is clear, the external analog switch routes the unknown input to the integrator. When the top bit sets, the switch routes the fixed negative reference to the integrator and the run-down phase begins.

During run-down an external comparator signals when the integrator output has fallen below ground. That bit is resynchronized, stops the counter and ends the conversion. The lower bits of the frozen counter give the number of run-down clocks, which is proportional to the input. The result is captured and a completion flag is raised. If the counter reaches full scale before the comparator trips, the conversion ends with an over-range flag. Between conversions the shunt switch stays closed so the capacitor discharges. The integrator, comparator, reference and switch are analog parts outside this block.

Top module: `dsadc_ctrl`

## Requirements
- R1: After reset the shunt switch is closed (`shunt_open_o`=0), the counter reads 0, `sel_ref_o`, `done_o` and `over_o` are low and `result_o` is 0.
- R2: A start request (`start_i` high at a clock edge while no conversion is running) makes the counter read 0, opens the shunt switch (`shunt_open_o`=1) and clears `done_o`, `over_o` and `result_o` from the next cycle on.
- R3: `sel_ref_o` always equals bit CNT_W-1 of `count_o`: 0 routes the analog input, 1 routes the negative reference.
- R4: During run-up (top bit 0) the counter increments on every clock edge, whatever the comparator does. `sel_ref_o` therefore rises exactly 2^(CNT_W-1) cycles after the start was accepted.
- R5: `cmp_i` (1 = integrator below ground) passes through SYNC_STAGES flops. In run-down the counter keeps advancing while the synchronized bit is 0 and holds once it is 1. A rise of `cmp_i` seen in the cycle that the counter shows 2^(CNT_W-1)+N therefore yields a result of N+SYNC_STAGES.
- R6: When the counter halts in run-down, `done_o` rises in the same cycle. `result_o` equals `count_o` with the top bit removed, and `over_o` stays 0.
- R7: If the counter is all ones and still enabled, the conversion ends with `done_o`=1, `over_o`=1, the counter held at all ones and `result_o` all ones.
- R8: After completion, `done_o`, `over_o`, `result_o` and `count_o` hold and the shunt switch stays closed until the next start, whatever `cmp_i` does.
- R9: A start request while a conversion is running is ignored: the counter is not cleared and the result is unaffected.
- R10: If the synchronized comparator is already 1 when run-down begins, the conversion ends one cycle later with a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion request from the host |
| cmp_i | input | 1 | Asynchronous comparator bit, 1 = integrator below ground |
| sel_ref_o | output | 1 | Analog switch select: 0 input, 1 negative reference |
| shunt_open_o | output | 1 | 1 releases the capacitor shunt switch |
| count_o | output | CNT_W | Running counter value |
| result_o | output | CNT_W-1 | Run-down cycle count, valid while done_o is high |
| done_o | output | 1 | Conversion complete, held until next start |
| over_o | output | 1 | Conversion ended by counter reaching full scale |

## Verification
Properties check on every cycle that the counter only steps by one or holds, that run-up never stalls, that a tripped comparator in run-down freezes the count and raises completion, that completion implies a closed shunt, that an over-range flag comes with an all-ones result, and that a mid-conversion start never clears the counter. Only the bench scenarios can show the arithmetic end to end: the exact run-up length, the result N+SYNC_STAGES for each trip point across the whole run-down range, the boundary between the largest valid result and over-range, the zero result, and the holding of results across idle periods with a toggling comparator.

// File: rtl/dsadc_pkg.sv
// Package: shared types for the dual-slope conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dsadc_pkg;

    // Conversion phases of the sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

endpackage

// File: rtl/dsadc_sync.sv
// Module: multi-flop resynchronizer for one asynchronous bit.
// Assumes: input is a level that stays stable for several clocks; reset
// value of the chain is 0 (integrator above ground).
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dsadc_counter.sv
// Module: conversion counter shared by both slopes; never reloaded
// between run-up and run-down.
// Assumes: clear and advance come from the sequencer; clear has priority.
module dsadc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             advance_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             msb_o,
    output logic             at_full_o
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Counter register: clear on start, step by one when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (clear_i)   cnt_q <= '0;
        else if (advance_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o     = cnt_q;
    assign msb_o     = cnt_q[CNT_W-1];
    assign at_full_o = (cnt_q == FULL);

    // R4: the count only holds or steps by one unless cleared.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    // R2: a clear always leaves the counter at zero.
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/dsadc_seq.sv
// Module: phase sequencer. Accepts start requests, gates the counter with
// the synchronized comparator during run-down, detects trip and overflow,
// and drives the shunt release and completion flags.
// Assumes: msb_i and at_full_i come from the shared counter; cmp_sync_i is
// already resynchronized.
module dsadc_seq
    import dsadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic msb_i,
    input  logic at_full_i,
    input  logic cmp_sync_i,
    output logic clear_o,
    output logic advance_o,
    output logic finish_o,
    output logic shunt_open_o,
    output logic done_o,
    output logic over_o
);

    phase_t phase_q;
    logic   running;
    logic   accept;
    logic   enable;
    logic   tripped;
    logic   overflow;
    logic   shunt_q;
    logic   done_q;
    logic   over_q;

    // Decode of start acceptance, count enable and end conditions.
    always_comb begin
        running  = (phase_q == PH_RUN);
        accept   = start_i && !running;
        enable   = running && (!msb_i || !cmp_sync_i);
        tripped  = running && msb_i && cmp_sync_i;
        overflow = enable && at_full_i;
    end

    // Phase register: idle -> run on start, run -> done on trip or overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)                    phase_q <= PH_IDLE;
        else if (accept)               phase_q <= PH_RUN;
        else if (tripped || overflow)  phase_q <= PH_DONE;
    end

    // Shunt release: open for the whole conversion, closed otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                    shunt_q <= 1'b0;
        else if (accept)               shunt_q <= 1'b1;
        else if (tripped || overflow)  shunt_q <= 1'b0;
    end

    // Completion flag: set at the end, held until the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                    done_q <= 1'b0;
        else if (accept)               done_q <= 1'b0;
        else if (tripped || overflow)  done_q <= 1'b1;
    end

    // Over-range flag: set only when the counter hit full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)        over_q <= 1'b0;
        else if (accept)   over_q <= 1'b0;
        else if (overflow) over_q <= 1'b1;
    end

    assign clear_o      = accept;
    assign advance_o    = enable && !at_full_i;
    assign finish_o     = tripped || overflow;
    assign shunt_open_o = shunt_q;
    assign done_o       = done_q;
    assign over_o       = over_q;

    // R8: completion and an open shunt never coexist.
    assert_done_shunt_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !shunt_q);

    // R8: completion stays up until a start is accepted.
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start_i) |=> done_q);

    // R7: an over-range flag always comes with completion.
    assert_over_has_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        over_q |-> done_q);

endmodule

// File: rtl/dsadc_ctrl.sv
// Module: top of the dual-slope conversion controller. Ties the comparator
// resynchronizer, the shared counter and the phase sequencer together and
// captures the run-down count as the result.
// Assumes: start_i is synchronous to clk; cmp_i is asynchronous and is 1
// when the integrator output is below ground.
module dsadc_ctrl #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             sel_ref_o,
    output logic             shunt_open_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-2:0] result_o,
    output logic             done_o,
    output logic             over_o
);

    localparam int               RES_W = CNT_W - 1;
    localparam logic [CNT_W-1:0] HALF  = {1'b1, {RES_W{1'b0}}};

    logic             cmp_s;
    logic             clear;
    logic             advance;
    logic             finish;
    logic             msb;
    logic             at_full;
    logic [CNT_W-1:0] cnt;
    logic [RES_W-1:0] result_q;

    dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_i),
        .sync_o  (cmp_s)
    );

    dsadc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .advance_i (advance),
        .cnt_o     (cnt),
        .msb_o     (msb),
        .at_full_o (at_full)
    );

    dsadc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .msb_i        (msb),
        .at_full_i    (at_full),
        .cmp_sync_i   (cmp_s),
        .clear_o      (clear),
        .advance_o    (advance),
        .finish_o     (finish),
        .shunt_open_o (shunt_open_o),
        .done_o       (done_o),
        .over_o       (over_o)
    );

    // Result capture: cleared on start, loaded with the low bits at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)      result_q <= '0;
        else if (clear)  result_q <= '0;
        else if (finish) result_q <= cnt[RES_W-1:0];
    end

    assign sel_ref_o = msb;
    assign count_o   = cnt;
    assign result_o  = result_q;

    // R4: run-up never stalls, whatever the comparator shows.
    assert_runup_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shunt_open_o && !sel_ref_o && !start_i) |=> (count_o == $past(count_o) + 1'b1));

    // R4: run-down begins only after the counter passes half scale.
    assert_rundown_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref_o) |-> ($past(count_o) == HALF - 1'b1));

    // R5: a tripped comparator in run-down freezes the count and ends it.
    assert_trip_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shunt_open_o && sel_ref_o && cmp_s) |=> (done_o && $stable(count_o)));

    // R7: over-range reports a saturated result.
    assert_over_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        over_o |-> (&result_o));

    // R9: a start during a conversion never clears the counter.
    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shunt_open_o && start_i) |=> (count_o != '0));

endmodule

// File: tb/tb_dsadc_ctrl.sv
// Bench: sweeps every run-down trip point of a small counter, plus
// over-range, zero-result, ignored-start and hold cases.
module tb_dsadc_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 5;
    localparam int SYNC       = 2;
    localparam int HALF       = 1 << (W - 1);
    localparam int FULLRES    = HALF - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic           cmp_i = 1'b0;
    logic           sel_ref_o;
    logic           shunt_open_o;
    logic [W-1:0]   count_o;
    logic [W-2:0]   result_o;
    logic           done_o;
    logic           over_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    dsadc_ctrl #(.CNT_W(W), .SYNC_STAGES(SYNC)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cmp_i        (cmp_i),
        .sel_ref_o    (sel_ref_o),
        .shunt_open_o (shunt_open_o),
        .count_o      (count_o),
        .result_o     (result_o),
        .done_o       (done_o),
        .over_o       (over_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // One conversion. trip >= 0: comparator rises when count shows HALF+trip;
    // trip == -1: never rises; trip == -2: high throughout.
    // noisy_runup: comparator high early in run-up. mid_start: pulse start mid-run.
    task automatic convert(input int trip, input bit noisy_runup, input bit mid_start);
        int  cyc;
        int  rise_cyc;
        bit  sel_ok;
        int  exp_res;
        bit  exp_over;
        @(negedge clk);
        start_i = 1'b1;
        cmp_i   = (trip == -2) || noisy_runup;
        @(negedge clk);
        start_i = 1'b0;
        // R2: counter cleared, shunt opened, flags cleared.
        check(count_o == 0 && shunt_open_o && !done_o && !over_o && result_o == 0,
              "R2", {27'd0, count_o}, 0);
        cyc = 0; rise_cyc = -1; sel_ok = 1'b1;
        while (!done_o && cyc < 4 * HALF + 10) begin
            if (trip == -2)                          cmp_i = 1'b1;
            else if (noisy_runup && count_o < HALF - 4) cmp_i = 1'b1;
            else if (trip >= 0 && int'(count_o) == HALF + trip) cmp_i = 1'b1;
            else if (trip >= 0 && int'(count_o) > HALF + trip)  cmp_i = 1'b1;
            else                                     cmp_i = 1'b0;
            start_i = mid_start && (cyc == 5);
            @(negedge clk);
            cyc++;
            if (sel_ref_o !== count_o[W-1]) sel_ok = 1'b0;
            if (sel_ref_o && rise_cyc < 0) rise_cyc = cyc;
        end
        start_i = 1'b0;
        check(sel_ok, "R3", 0, 0);
        // R4: run-up length fixed at HALF cycles.
        check(rise_cyc == HALF, "R4", rise_cyc, HALF);
        if (trip == -2)          begin exp_res = 0;         exp_over = 1'b0; end
        else if (trip == -1)     begin exp_res = FULLRES;   exp_over = 1'b1; end
        else if (trip + SYNC > FULLRES) begin exp_res = FULLRES; exp_over = 1'b1; end
        else                     begin exp_res = trip + SYNC; exp_over = 1'b0; end
        if (trip == -2)
            check(done_o && result_o == 0, "R10", int'(result_o), 0);
        else if (exp_over)
            check(done_o && over_o && result_o == FULLRES && count_o == {W{1'b1}},
                  "R7", int'(result_o), FULLRES);
        else
            check(done_o && result_o == exp_res, "R5", int'(result_o), exp_res);
        // R6: result is count without top bit, over stays clear when tripped.
        check(result_o == count_o[W-2:0] && over_o == exp_over && !shunt_open_o,
              "R6", int'(over_o), int'(exp_over));
        if (mid_start)
            check(result_o == exp_res, "R9", int'(result_o), exp_res);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(count_o == 0 && !shunt_open_o && !sel_ref_o && !done_o && !over_o
              && result_o == 0, "R1", int'(count_o), 0);
        // R5/R6/R7: sweep every trip point across run-down, past full scale.
        for (int t = 0; t < HALF; t++) convert(t, t[0], 1'b0);
        convert(-1, 1'b0, 1'b0);
        // R10: comparator already high at run-down entry.
        convert(-2, 1'b0, 1'b0);
        // R9: start pulsed during run-up, result unaffected.
        convert(3, 1'b0, 1'b1);
        // R8: hold after completion while comparator toggles.
        for (int k = 0; k < 12; k++) begin
            cmp_i = k[0];
            @(negedge clk);
        end
        check(done_o && result_o == 3 + SYNC && count_o == HALF + 3 + SYNC
              && !shunt_open_o && !over_o, "R8", int'(result_o), 3 + SYNC);
        // R2: restart after completion clears everything again.
        convert(FULLRES - SYNC, 1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule